// File: doc/BRIEF.md
# Link Bring-up Procedure Sequencer

This block lets a host pick one of a small set of numbered link bring-up procedures and run it to completion by polling. The host sees a 32-bit access window with two word locations. A write of a procedure number at byte offset 4 arms that procedure. Each read of the status word at byte offset 0 advances the armed procedure. Every procedure is an ordered list of steps. Steps that do real work are carried out by external step engines through a request/acknowledge handshake. A few slots are handled inside the block and finish at once.

A status read that finds the procedure unfinished asks the engine to evaluate the current step. The engine answers with one of three outcomes: still busy, advance, or done with a result code. When the answer is advance, the step index moves on and the next step is evaluated within the same read. The status read therefore finishes only on a busy or done outcome. A procedure that stays busy for longer than a timebase limit after it was armed is closed as failed. The engines also get a 32-bit scratch word, which they may update on acknowledge and which is cleared whenever a procedure is armed.

Top module: `linkproc_ctl`

## Requirements
- R1: After reset the stored status, procedure number, step index and scratch word are all zero. No response is pending and no engine request is raised.
- R2: An access whose size field is not 4 gets an error response with read data 0 and changes no state.
- R3: An access of size 4 at any byte offset other than 0 or 4 gets an error response with read data 0 and changes no state.
- R4: A write to offset 0 is accepted without error and has no effect on the status.
- R5: Writing a number of 13 or more, or the number 2 or 3, sets the status to 0x40000004 (complete, unsupported) and leaves the stored procedure number unchanged.
- R6: Writing a supported number (0, 1 or 4..12) sets the status to 0x80000000 (in progress), stores the number (readable at offset 4), clears the step index and the scratch word, and captures the timebase.
- R7: A status read while bit 30 (complete) is set returns the stored status unchanged and raises no engine request.
- R8: A status read of an unfinished procedure 0 returns 0x40000003 (complete, aborted). Procedures 1, 11 and 12 return 0x40000000. None of these raise an engine request.
- R9: For procedures 4..10, a status read raises `eng_req_o` with the number and step held stable until `eng_ack_i`. Outcome encodings are 0 busy, 1 advance and 2 done. The scratch word takes `eng_scratch_i` on an acknowledge with `eng_scratch_we_i` set.
- R10: An advance outcome increments the step index and evaluates the next step within the same status read. The step index persists between reads.
- R11: A done outcome sets the status to 0x40000000 ORed with the 4-bit engine code.
- R12: A busy outcome yields 0x80000000 while (timebase minus captured timebase, modulo 2^TB_W) is at most TIMEOUT_TICKS, and 0x40000002 (complete, failed) once it is strictly greater.
- R13: Each accepted access gets exactly one response, as a one-cycle `rsp_valid_o` pulse.
- R14: Status words returned to the host carry only bits 31, 30 and 3:0. In particular the internal advance flag (bit 29) is never visible, and bits 31 and 30 are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request, taken when the block is idle |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_offset_i | input | OFF_W | Byte offset within the window |
| req_size_i | input | 3 | Access size in bytes |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_error_o | output | 1 | Access rejected |
| rsp_rdata_o | output | 32 | Read data |
| timebase_i | input | TB_W | Free-running timebase |
| eng_req_o | output | 1 | Step evaluation request |
| eng_proc_o | output | IDX_W | Procedure number under evaluation |
| eng_step_o | output | STEP_W | Step index under evaluation |
| eng_scratch_o | output | 32 | Scratch word for the engine |
| eng_ack_i | input | 1 | Engine answer valid |
| eng_result_i | input | 2 | Outcome: 0 busy, 1 advance, 2 done |
| eng_code_i | input | 4 | Result code with a done outcome |
| eng_scratch_we_i | input | 1 | Update scratch word on acknowledge |
| eng_scratch_i | input | 32 | New scratch word |

## Verification
Every procedure number from 0 to 15 is written, plus two far out-of-range values. This separates the supported, empty and built-in slots, and it shows that a rejected number leaves the previous one in place. Chains of zero to five advance outcomes are run under zero to two cycles of engine latency. Each chain ends with a distinct code, so the final status, the acknowledge count and the last step index reveal a lost or extra step. Polling a stuck procedure at exactly the limit and at one tick past it separates a strict compare from an inclusive one, and a start time near the top of the timebase range checks the modular elapsed time. Sweeps of the size and offset fields show that every malformed access is rejected with no side effect.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam logic [31:0] ST_BUSY  = 32'h8000_0000;
  localparam logic [31:0] ST_DONE  = 32'h4000_0000;
  localparam logic [31:0] ST_ADV   = 32'h2000_0000;
  localparam logic [31:0] VIS_MASK = 32'hC000_000F;

  localparam logic [3:0] CODE_FAIL  = 4'd2;
  localparam logic [3:0] CODE_ABORT = 4'd3;
  localparam logic [3:0] CODE_UNSUP = 4'd4;

  typedef enum logic [1:0] {OUT_BUSY = 2'd0, OUT_NEXT = 2'd1, OUT_DONE = 2'd2} outcome_e;
  typedef enum logic [1:0] {SLOT_EMPTY, SLOT_ABORT, SLOT_NOP, SLOT_ENGINE} slot_e;
  typedef enum logic [2:0] {ACC_BAD, ACC_WR_STAT, ACC_WR_NUM, ACC_RD_STAT, ACC_RD_NUM} acc_e;
  typedef enum logic {S_IDLE, S_EVAL} state_e;
endpackage

// File: rtl/lpc_decode.sv
module lpc_decode
  import lpc_pkg::*;
#(
  parameter int unsigned OFF_W = 8
) (
  input  logic             write_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [2:0]       size_i,
  output acc_e             acc_o
);
  always_comb begin
    acc_o = ACC_BAD;
    if (size_i == 3'd4) begin
      if (offset_i == OFF_W'(0))      acc_o = write_i ? ACC_WR_STAT : ACC_RD_STAT;
      else if (offset_i == OFF_W'(4)) acc_o = write_i ? ACC_WR_NUM  : ACC_RD_NUM;
    end
  end
endmodule

// File: rtl/lpc_slot_map.sv
module lpc_slot_map
  import lpc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 13,
  parameter int unsigned ENG_FIRST = 4,
  parameter int unsigned ENG_LAST  = 10,
  parameter int unsigned IDX_W     = 4
) (
  input  logic [31:0] num_i,
  output slot_e       kind_o
);
  localparam int unsigned TAB_N = 1 << IDX_W;

  slot_e kind_tab [TAB_N];

  for (genvar g = 0; g < TAB_N; g++) begin : g_slot
    if (g >= NUM_SLOTS || (g >= 2 && g < ENG_FIRST)) begin : g_empty
      assign kind_tab[g] = SLOT_EMPTY;
    end else if (g == 0) begin : g_abort
      assign kind_tab[g] = SLOT_ABORT;
    end else if (g >= ENG_FIRST && g <= ENG_LAST) begin : g_eng
      assign kind_tab[g] = SLOT_ENGINE;
    end else begin : g_nop
      assign kind_tab[g] = SLOT_NOP;
    end
  end

  assign kind_o = (num_i < NUM_SLOTS) ? kind_tab[num_i[IDX_W-1:0]] : SLOT_EMPTY;
endmodule

// File: rtl/lpc_timeout.sv
module lpc_timeout #(
  parameter int unsigned      TB_W  = 64,
  parameter logic [TB_W-1:0]  LIMIT = '0
) (
  input  logic [TB_W-1:0] now_i,
  input  logic [TB_W-1:0] start_i,
  output logic            expired_o
);
  logic [TB_W-1:0] elapsed;

  // modular difference survives timebase wrap
  assign elapsed   = now_i - start_i;
  assign expired_o = elapsed > LIMIT;
endmodule

// File: rtl/linkproc_ctl.sv
module linkproc_ctl
  import lpc_pkg::*;
#(
  parameter int unsigned     OFF_W         = 8,
  parameter int unsigned     TB_W          = 64,
  parameter int unsigned     STEP_W        = 4,
  parameter int unsigned     NUM_SLOTS     = 13,
  parameter int unsigned     ENG_FIRST     = 4,
  parameter int unsigned     ENG_LAST      = 10,
  parameter logic [TB_W-1:0] TIMEOUT_TICKS = TB_W'(51_200_000),
  localparam int unsigned    IDX_W         = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [OFF_W-1:0]  req_offset_i,
  input  logic [2:0]        req_size_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_error_o,
  output logic [31:0]       rsp_rdata_o,
  input  logic [TB_W-1:0]   timebase_i,
  output logic              eng_req_o,
  output logic [IDX_W-1:0]  eng_proc_o,
  output logic [STEP_W-1:0] eng_step_o,
  output logic [31:0]       eng_scratch_o,
  input  logic              eng_ack_i,
  input  logic [1:0]        eng_result_i,
  input  logic [3:0]        eng_code_i,
  input  logic              eng_scratch_we_i,
  input  logic [31:0]       eng_scratch_i
);
  state_e            state_q;
  logic [31:0]       status_q, scratch_q, rsp_data_q;
  logic [IDX_W-1:0]  num_q;
  logic [STEP_W-1:0] step_q;
  logic [TB_W-1:0]   start_q;
  logic              rsp_valid_q, rsp_err_q;

  acc_e        acc;
  slot_e       wr_kind, cur_kind;
  logic        expired;
  logic [31:0] builtin_st, eval_st;

  lpc_decode #(.OFF_W(OFF_W)) u_decode (
    .write_i (req_write_i),
    .offset_i(req_offset_i),
    .size_i  (req_size_i),
    .acc_o   (acc)
  );

  lpc_slot_map #(
    .NUM_SLOTS(NUM_SLOTS), .ENG_FIRST(ENG_FIRST), .ENG_LAST(ENG_LAST), .IDX_W(IDX_W)
  ) u_wr_map (
    .num_i (req_wdata_i),
    .kind_o(wr_kind)
  );

  lpc_slot_map #(
    .NUM_SLOTS(NUM_SLOTS), .ENG_FIRST(ENG_FIRST), .ENG_LAST(ENG_LAST), .IDX_W(IDX_W)
  ) u_cur_map (
    .num_i ({{(32-IDX_W){1'b0}}, num_q}),
    .kind_o(cur_kind)
  );

  lpc_timeout #(.TB_W(TB_W), .LIMIT(TIMEOUT_TICKS)) u_timeout (
    .now_i    (timebase_i),
    .start_i  (start_q),
    .expired_o(expired)
  );

  always_comb begin
    builtin_st = (cur_kind == SLOT_ABORT) ? (ST_DONE | {28'b0, CODE_ABORT}) : ST_DONE;
    case (eng_result_i)
      OUT_NEXT: eval_st = ST_ADV;
      OUT_DONE: eval_st = ST_DONE | {28'b0, eng_code_i};
      default:  eval_st = expired ? (ST_DONE | {28'b0, CODE_FAIL}) : ST_BUSY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      status_q    <= '0;
      num_q       <= '0;
      step_q      <= '0;
      scratch_q   <= '0;
      start_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (state_q == S_IDLE && req_valid_i) begin
        rsp_valid_q <= 1'b1;
        rsp_err_q   <= 1'b0;
        rsp_data_q  <= '0;
        case (acc)
          ACC_BAD: rsp_err_q <= 1'b1;
          ACC_WR_NUM: begin
            if (wr_kind == SLOT_EMPTY) begin
              status_q <= ST_DONE | {28'b0, CODE_UNSUP};
            end else begin
              status_q  <= ST_BUSY;
              num_q     <= req_wdata_i[IDX_W-1:0];
              step_q    <= '0;
              scratch_q <= '0;
              start_q   <= timebase_i;
            end
          end
          ACC_RD_NUM: rsp_data_q <= {{(32-IDX_W){1'b0}}, num_q};
          ACC_RD_STAT: begin
            if (status_q[30]) begin
              rsp_data_q <= status_q;
            end else if (cur_kind == SLOT_ENGINE) begin
              rsp_valid_q <= 1'b0;
              state_q     <= S_EVAL;
            end else begin
              status_q   <= builtin_st;
              rsp_data_q <= builtin_st;
            end
          end
          default: ;
        endcase
      end else if (state_q == S_EVAL && eng_ack_i) begin
        if (eng_scratch_we_i) scratch_q <= eng_scratch_i;
        if (eval_st[29]) begin
          step_q <= step_q + 1'b1;
        end else begin
          status_q    <= eval_st & VIS_MASK;
          rsp_data_q  <= eval_st & VIS_MASK;
          rsp_err_q   <= 1'b0;
          rsp_valid_q <= 1'b1;
          state_q     <= S_IDLE;
        end
      end
    end
  end

  assign rsp_valid_o   = rsp_valid_q;
  assign rsp_error_o   = rsp_err_q;
  assign rsp_rdata_o   = rsp_data_q;
  assign eng_req_o     = (state_q == S_EVAL);
  assign eng_proc_o    = num_q;
  assign eng_step_o    = step_q;
  assign eng_scratch_o = scratch_q;
endmodule

// File: rtl/lpc_checker.sv
module lpc_checker #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned STEP_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rsp_valid_o,
  input logic              rsp_error_o,
  input logic [31:0]       rsp_rdata_o,
  input logic              eng_req_o,
  input logic [IDX_W-1:0]  eng_proc_o,
  input logic [STEP_W-1:0] eng_step_o,
  input logic              eng_ack_i,
  input logic [1:0]        eng_result_i
);
  // R2
  err_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_error_o |-> rsp_rdata_o == 32'd0);

  // R14
  hidden_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_error_o |-> rsp_rdata_o[29:4] == '0 && !(rsp_rdata_o[31] && rsp_rdata_o[30]));

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && !eng_ack_i |=> eng_req_o && $stable(eng_step_o) && $stable(eng_proc_o));

  // R10
  step_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && eng_ack_i && eng_result_i == 2'd1 |=> eng_req_o && eng_step_o == $past(eng_step_o) + 1'b1);

  // R9
  eval_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && eng_ack_i && eng_result_i != 2'd1 |=> !eng_req_o && rsp_valid_o);

  // R13
  no_rsp_during_eval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o |-> !rsp_valid_o);
endmodule

bind linkproc_ctl lpc_checker #(.IDX_W(IDX_W), .STEP_W(STEP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rsp_valid_o (rsp_valid_o),
  .rsp_error_o (rsp_error_o),
  .rsp_rdata_o (rsp_rdata_o),
  .eng_req_o   (eng_req_o),
  .eng_proc_o  (eng_proc_o),
  .eng_step_o  (eng_step_o),
  .eng_ack_i   (eng_ack_i),
  .eng_result_i(eng_result_i)
);

// File: tb/linkproc_ctl_tb.sv
`timescale 1ns/1ps
module linkproc_ctl_tb;
  localparam int unsigned TB_W = 64;
  localparam logic [63:0] TO   = 64'd1000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [7:0]  req_offset_i = '0;
  logic [2:0]  req_size_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o, rsp_error_o;
  logic [31:0] rsp_rdata_o;
  logic [63:0] tbase = '0;
  logic        eng_req_o, eng_ack_i;
  logic [3:0]  eng_proc_o, eng_step_o;
  logic [31:0] eng_scratch_o;
  logic [1:0]  eng_result_i;
  logic [3:0]  eng_code_i;
  logic        eng_scratch_we_i;
  logic [31:0] eng_scratch_i;

  localparam logic [31:0] SCR_VAL = 32'h5C5C_0001;

  always #2.5 clk_i = ~clk_i;

  linkproc_ctl #(.TB_W(TB_W), .TIMEOUT_TICKS(TO)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_offset_i(req_offset_i),
    .req_size_i(req_size_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_error_o(rsp_error_o), .rsp_rdata_o(rsp_rdata_o),
    .timebase_i(tbase),
    .eng_req_o(eng_req_o), .eng_proc_o(eng_proc_o), .eng_step_o(eng_step_o),
    .eng_scratch_o(eng_scratch_o), .eng_ack_i(eng_ack_i), .eng_result_i(eng_result_i),
    .eng_code_i(eng_code_i), .eng_scratch_we_i(eng_scratch_we_i), .eng_scratch_i(eng_scratch_i)
  );

  // step engine stub
  logic [1:0] stub_res [16];
  logic [3:0] stub_code = '0;
  int         stub_delay = 0;
  int         wait_cnt = 0;
  int         acks = 0;
  int         last_step = 0;
  logic [31:0] seen_scr = '0;

  assign eng_ack_i        = eng_req_o && (wait_cnt >= stub_delay);
  assign eng_result_i     = stub_res[eng_step_o];
  assign eng_code_i       = stub_code;
  assign eng_scratch_we_i = eng_ack_i && (eng_step_o == 4'd0);
  assign eng_scratch_i    = SCR_VAL;

  always @(posedge clk_i) begin
    if (eng_req_o && !eng_ack_i) wait_cnt <= wait_cnt + 1;
    else                         wait_cnt <= 0;
    if (eng_req_o && eng_ack_i) begin
      acks      <= acks + 1;
      last_step <= int'(eng_step_o);
    end
    if (eng_req_o && eng_step_o == 4'd0) seen_scr <= eng_scratch_o;
  end

  int nchk = 0, nfail = 0, cyc = 0;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nfail = nfail + 1;
      $display("FAIL R13 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [7:0] off, input logic [2:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd, output bit er);
    bit got = 0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = wr; req_offset_i = off; req_size_i = sz; req_wdata_i = wd;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    rd = '0; er = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (rsp_valid_o) begin
        rd = rsp_rdata_o; er = rsp_error_o; got = 1;
        break;
      end
      @(negedge clk_i);
    end
    chk(got, "R13 response", 64'(got), 64'd1);
    @(negedge clk_i);
    chk(!rsp_valid_o, "R13 single pulse", 64'(rsp_valid_o), 64'd0);
  endtask

  task automatic wr_num(input logic [31:0] n);
    logic [31:0] rd; bit er;
    acc(1'b1, 8'd4, 3'd4, n, rd, er);
    chk(!er, "R6 write accepted", 64'(er), 64'd0);
  endtask

  task automatic rd_stat(output logic [31:0] st);
    bit er;
    acc(1'b0, 8'd0, 3'd4, 32'd0, st, er);
  endtask

  task automatic rd_num(output logic [31:0] n);
    bit er;
    acc(1'b0, 8'd4, 3'd4, 32'd0, n, er);
  endtask

  initial begin
    logic [31:0] rd, exp_st;
    bit er;
    int a0;
    for (int i = 0; i < 16; i++) stub_res[i] = 2'd2;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!rsp_valid_o && !eng_req_o, "R1 idle after reset", {rsp_valid_o, eng_req_o}, 0);
    chk(eng_scratch_o == 0 && eng_step_o == 0, "R1 scratch/step zero", {eng_scratch_o, 28'b0, eng_step_o}, 0);
    rst_ni = 1'b1;
    rd_num(rd);
    chk(rd == 0, "R1 number zero", rd, 0);
    a0 = acks;
    rd_stat(rd);
    chk(rd == 32'h4000_0003, "R8 proc0 aborts", rd, 32'h4000_0003);
    chk(acks == a0, "R8 no engine for proc0", acks - a0, 0);

    // sweep of procedure numbers
    for (int n = 0; n < 18; n++) begin
      logic [31:0] num;
      bit valid, eng;
      num = (n == 16) ? 32'd100 : (n == 17) ? 32'hFFFF_FFFF : 32'(n);
      valid = (num < 13) && (num != 2) && (num != 3);
      eng = (num >= 4) && (num <= 10);
      wr_num(32'd1);
      rd_stat(rd);
      chk(rd == 32'h4000_0000, "R8 proc1 nop", rd, 32'h4000_0000);
      stub_res[0] = 2'd2; stub_code = num[3:0]; stub_delay = 0;
      wr_num(num);
      a0 = acks;
      rd_num(rd);
      if (!valid) begin
        chk(rd == 1, "R5 number kept", rd, 1);
        rd_stat(rd);
        chk(rd == 32'h4000_0004, "R5 unsupported", rd, 32'h4000_0004);
      end else begin
        chk(rd == num, "R6 number stored", rd, num);
        rd_stat(rd);
        if (eng) exp_st = 32'h4000_0000 | num;
        else if (num == 0) exp_st = 32'h4000_0003;
        else exp_st = 32'h4000_0000;
        chk(rd == exp_st, eng ? "R11 engine done code" : "R8 builtin", rd, exp_st);
        chk((acks - a0) == (eng ? 1 : 0), "R9 engine request count", acks - a0, eng ? 1 : 0);
      end
    end

    // step chains with engine latency
    for (int k = 0; k < 6; k++) begin
      for (int d = 0; d < 3; d++) begin
        for (int i = 0; i < 16; i++) stub_res[i] = (i < k) ? 2'd1 : 2'd2;
        stub_code = 4'(k + 1); stub_delay = d;
        wr_num(32'd6);
        a0 = acks;
        rd_stat(rd);
        chk(rd == (32'h4000_0000 | 32'(k + 1)), "R10 chain status", rd, 32'h4000_0000 | 32'(k + 1));
        chk(acks - a0 == k + 1, "R10 chain evaluations", acks - a0, k + 1);
        chk(last_step == k, "R10 final step index", last_step, k);
        a0 = acks;
        rd_stat(rd);
        chk(rd == (32'h4000_0000 | 32'(k + 1)), "R7 sticky status", rd, 32'h4000_0000 | 32'(k + 1));
        chk(acks == a0, "R7 no engine request", acks - a0, 0);
      end
    end

    // in progress and timeout
    stub_delay = 0;
    stub_res[0] = 2'd1; stub_res[1] = 2'd0;
    tbase = 64'd5000;
    wr_num(32'd7);
    tbase = 64'd5005;
    a0 = acks;
    rd_stat(rd);
    chk(rd == 32'h8000_0000, "R12 busy", rd, 32'h8000_0000);
    chk(acks - a0 == 2 && last_step == 1, "R10 advance then busy", acks - a0, 2);
    a0 = acks;
    rd_stat(rd);
    chk(acks - a0 == 1 && last_step == 1, "R10 step persists", last_step, 1);
    tbase = 64'd5000 + TO;
    rd_stat(rd);
    chk(rd == 32'h8000_0000, "R12 at limit", rd, 32'h8000_0000);
    tbase = 64'd5001 + TO;
    rd_stat(rd);
    chk(rd == 32'h4000_0002, "R12 past limit", rd, 32'h4000_0002);
    a0 = acks;
    rd_stat(rd);
    chk(rd == 32'h4000_0002 && acks == a0, "R7 failed sticky", rd, 32'h4000_0002);

    // timeout across timebase wrap
    tbase = 64'hFFFF_FFFF_FFFF_FFF6;
    wr_num(32'd7);
    tbase = TO - 64'd11;
    rd_stat(rd);
    chk(rd == 32'h8000_0000, "R12 wrap within limit", rd, 32'h8000_0000);
    tbase = TO - 64'd9;
    rd_stat(rd);
    chk(rd == 32'h4000_0002, "R12 wrap past limit", rd, 32'h4000_0002);
    chk(eng_scratch_o == SCR_VAL, "R9 scratch written", eng_scratch_o, SCR_VAL);

    // restart clears step and scratch
    stub_res[0] = 2'd2; stub_code = 4'd9;
    wr_num(32'd7);
    rd_stat(rd);
    chk(rd == 32'h4000_0009, "R6 restart status", rd, 32'h4000_0009);
    chk(last_step == 0, "R6 step cleared", last_step, 0);
    chk(seen_scr == 0, "R6 scratch cleared", seen_scr, 0);

    // write to status ignored
    acc(1'b1, 8'd0, 3'd4, 32'h8000_0000, rd, er);
    chk(!er, "R4 write accepted", er, 0);
    a0 = acks;
    rd_stat(rd);
    chk(rd == 32'h4000_0009 && acks == a0, "R4 status unchanged", rd, 32'h4000_0009);

    // size sweep
    for (int s = 0; s < 8; s++) begin
      if (s == 4) continue;
      acc(1'b1, 8'd4, 3'(s), 32'd1, rd, er);
      chk(er && rd == 0, "R2 bad size rejected", {er, rd}, {1'b1, 32'd0});
      rd_num(rd);
      chk(rd == 7, "R2 number unchanged", rd, 7);
    end

    // offset sweep
    for (int o = 0; o < 18; o++) begin
      logic [7:0] off;
      off = (o == 16) ? 8'h80 : (o == 17) ? 8'hFC : 8'(o);
      if (off == 0 || off == 4) continue;
      acc(1'b0, off, 3'd4, 32'd0, rd, er);
      chk(er && rd == 0, "R3 bad offset rejected", {er, rd}, {1'b1, 32'd0});
    end
    acc(1'b1, 8'd8, 3'd4, 32'd1, rd, er);
    chk(er, "R3 bad offset write rejected", er, 1);
    rd_num(rd);
    chk(rd == 7, "R3 number unchanged", rd, 7);

    summary();
    $finish;
  end
endmodule